// File: doc/BRIEF.md
# Serial ADC Host Reader

This block sits on the host side of a three-wire link to a 12-bit successive-approximation converter. It drives the conversion-start pin and the serial clock, and it gathers the bit stream the converter returns. Each frame opens with one conversion pulse and is followed by sixteen serial clock pulses. From the bits captured on the rising serial edges, the block keeps a reference-settled flag and a 12-bit code, MSB first, and drops the rest. The code is presented right-justified together with the flag and a one-cycle valid strobe. One LSB of the code is the converter's full scale divided by 4096.

A frame starts on a start pulse, or back to back while the continuous input is held. On request, and only while the link is quiet, the block can put the converter into a light or a deep power-down. It does this by pulsing the conversion pin two or four times while the serial clock stays low. A single serial clock pulse wakes it again. All pin timing is a whole number of system clocks set by a divider parameter.

The controller has eight states. IDLE waits for work. CONV holds the conversion pin high. SCK_LO and SCK_HI form the two halves of each serial clock. PW_HI and PW_LO form the power-down pulses. PARK waits in power-down. WAKE issues the wake-up clock pulse. The transitions are: IDLE to CONV on launch; IDLE to PW_HI on a power request; CONV to SCK_LO; SCK_LO to SCK_HI; SCK_HI to SCK_LO between bits; SCK_HI to CONV (chained frame) or to IDLE after the last bit; PW_HI to PW_LO; PW_LO to PW_HI while pulses remain; PW_LO to PARK after the last pulse; PARK to WAKE on a wake request; WAKE to IDLE. Every transition happens only on a divider tick.

Top module: `adc_host_reader`

## Requirements
- R1: While reset is asserted and after it is released, conv, sclk and sample_vld are 0, and sample and ready_flag are 0.
- R2: A divider tick occurs every DIV system clocks, counted from reset. conv and sclk change only on the system edge that ends a tick cycle, so every pin level lasts a multiple of DIV clocks. A frame consists of one tick period with conv high, followed by 16 serial clocks, each one tick period low and then one tick period high.
- R3: sdo is captured on the system edge at which sclk rises. With the rising edges of a frame numbered 1 to 16, edge 2 carries the ready bit and edges 3 to 14 carry data bits 11 down to 0. Edges 1, 15 and 16 are discarded.
- R4: At the end of the high half of the 16th serial clock, sample (data bit 0 at sample[0]) and ready_flag update. On the following cycle, sample_vld is high for exactly one cycle. sample does not change at any other time.
- R5: If strict is high when a frame completes and the captured ready bit is 0, no strobe is issued, and sample and ready_flag keep their previous values.
- R6: A start pulse of one cycle is remembered until it launches a frame. A start that arrives during a frame launches the next frame directly after the last serial clock, with no idle tick.
- R7: While run_cont is high, frames repeat with the conv rises exactly 33 tick periods apart.
- R8: In IDLE, pwr_req = 2'b01 gives two conv pulses and pwr_req[1] = 1 gives four conv pulses. Each pulse is one tick high and one tick low, sclk stays low throughout, and the block then parks.
- R9: While parked, conv and sclk stay low and a start is held pending. A wake_req produces one sclk high period of one tick, then IDLE, where any pending start launches. A wake_req outside PARK has no effect.
- R10: In IDLE, a frame request takes priority over a power request that arrives in the same cycle.
- R11: conv and sclk are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one frame (pulse) |
| run_cont | input | 1 | Repeat frames back to back while high |
| strict | input | 1 | Drop frames whose ready bit is 0 |
| pwr_req | input | 2 | Power-down request: 01 light, 1x deep |
| wake_req | input | 1 | Leave power-down |
| sdo | input | 1 | Serial data from the converter |
| conv | output | 1 | Conversion-start pin |
| sclk | output | 1 | Serial clock pin |
| sample | output | DATA_W | Right-justified conversion code |
| ready_flag | output | 1 | Ready bit of the last accepted frame |
| sample_vld | output | 1 | One-cycle strobe for a new sample |

## Verification
Two events can fall on the same system edge. The completion of a frame, which publishes the sample and raises the strobe one cycle later, can coincide with the conv rise of the next frame when a start arrived mid-frame or continuous mode is held. A start and a power request can also arrive together while the block is idle. The bench provokes the first case with run_cont and with a second start during a frame, and it provokes the second with both requests in one cycle. A behavioural model that counts tick phases judges both cases on every clock, and directed checks confirm the 33-tick conv spacing and that no power-down pulses follow the start.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_PW_HI,
        ST_PW_LO,
        ST_PARK,
        ST_WAKE
    } rd_state_e;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == CNT_W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_shreg.sv
module adc_rd_shreg #(
    parameter int FRAME_CLKS = 16,
    parameter int DATA_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdo,
    input  logic              pub_en,
    input  logic              strict,
    output logic [DATA_W-1:0] sample,
    output logic              ready_flag,
    output logic              sample_vld
);
    localparam int SH_W    = FRAME_CLKS - 1;
    localparam int RDY_POS = FRAME_CLKS - 2;
    localparam int DAT_TOP = FRAME_CLKS - 3;

    logic [SH_W-1:0] sh_q;
    logic            keep;

    assign keep = !(strict && !sh_q[RDY_POS]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            sample     <= '0;
            ready_flag <= 1'b0;
            sample_vld <= 1'b0;
        end else begin
            if (shift_en) begin
                sh_q <= {sh_q[SH_W-2:0], sdo};
            end
            sample_vld <= pub_en && keep;
            if (pub_en && keep) begin
                sample     <= sh_q[DAT_TOP -: DATA_W];
                ready_flag <= sh_q[RDY_POS];
            end
        end
    end
endmodule

// File: rtl/adc_host_reader.sv
module adc_host_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV        = 2,
    parameter int DATA_W     = 12,
    parameter int FRAME_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run_cont,
    input  logic              strict,
    input  logic [1:0]        pwr_req,
    input  logic              wake_req,
    input  logic              sdo,
    output logic              conv,
    output logic              sclk,
    output logic [DATA_W-1:0] sample,
    output logic              ready_flag,
    output logic              sample_vld
);
    localparam int BIT_W = $clog2(FRAME_CLKS);

    rd_state_e        st_q, st_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic [1:0]       pul_q, pul_d;
    logic             spend_q, spend_d;
    logic             wpend_q, wpend_d;
    logic             tick_w;
    logic             go, launch, wake_go, last_bit;
    logic             shift_en, pub_en;

    adc_rd_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w)
    );

    adc_rd_shreg #(.FRAME_CLKS(FRAME_CLKS), .DATA_W(DATA_W)) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .sdo        (sdo),
        .pub_en     (pub_en),
        .strict     (strict),
        .sample     (sample),
        .ready_flag (ready_flag),
        .sample_vld (sample_vld)
    );

    assign last_bit = (bit_q == BIT_W'(FRAME_CLKS - 1));
    assign go       = spend_q | start | run_cont;
    assign wake_go  = wpend_q | wake_req;

    always_comb begin
        st_d   = st_q;
        bit_d  = bit_q;
        pul_d  = pul_q;
        launch = 1'b0;
        if (tick_w) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (go) begin
                        st_d   = ST_CONV;
                        launch = 1'b1;
                    end else if (pwr_req[1]) begin
                        st_d  = ST_PW_HI;
                        pul_d = 2'd3;
                    end else if (pwr_req[0]) begin
                        st_d  = ST_PW_HI;
                        pul_d = 2'd1;
                    end
                end
                ST_CONV: begin
                    st_d  = ST_SCK_LO;
                    bit_d = '0;
                end
                ST_SCK_LO: st_d = ST_SCK_HI;
                ST_SCK_HI: begin
                    if (!last_bit) begin
                        st_d  = ST_SCK_LO;
                        bit_d = bit_q + 1'b1;
                    end else if (go) begin
                        st_d   = ST_CONV;
                        launch = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
                ST_PW_HI: st_d = ST_PW_LO;
                ST_PW_LO: begin
                    if (pul_q == 2'd0) begin
                        st_d = ST_PARK;
                    end else begin
                        st_d  = ST_PW_HI;
                        pul_d = pul_q - 1'b1;
                    end
                end
                ST_PARK: if (wake_go) st_d = ST_WAKE;
                ST_WAKE: st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
        spend_d = (spend_q | start) & ~launch;
        wpend_d = (st_q == ST_PARK) & wake_go & ~tick_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            bit_q   <= '0;
            pul_q   <= '0;
            spend_q <= 1'b0;
            wpend_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            bit_q   <= bit_d;
            pul_q   <= pul_d;
            spend_q <= spend_d;
            wpend_q <= wpend_d;
        end
    end

    always_comb begin
        conv     = (st_q == ST_CONV) || (st_q == ST_PW_HI);
        sclk     = (st_q == ST_SCK_HI) || (st_q == ST_WAKE);
        shift_en = tick_w && (st_q == ST_SCK_LO);
        pub_en   = tick_w && (st_q == ST_SCK_HI) && last_bit;
    end
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv,
    input logic              sclk,
    input logic              strict,
    input logic              tick_w,
    input logic [DATA_W-1:0] sample,
    input logic              ready_flag,
    input logic              sample_vld
);
    // R11
    conv_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv && sclk));

    // R2
    pin_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(conv) || !$stable(sclk)) |-> $past(tick_w));

    // R4
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

    // R4
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample) |-> sample_vld);

    // R5
    strict_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && $past(strict)) |-> ready_flag);
endmodule

bind adc_host_reader adc_rd_chk #(.DATA_W(DATA_W)) u_rd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv       (conv),
    .sclk       (sclk),
    .strict     (strict),
    .tick_w     (tick_w),
    .sample     (sample),
    .ready_flag (ready_flag),
    .sample_vld (sample_vld)
);

// File: tb/test_adc_host_reader.sv
module test_adc_host_reader;
    localparam int DIV = 3;
    localparam int FRM = 33 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, run_cont = 1'b0, strict = 1'b0, wake_req = 1'b0, sdo = 1'b1;
    logic [1:0] pwr_req = 2'b00;
    logic conv, sclk, ready_flag, sample_vld;
    logic [11:0] sample;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_host_reader #(.DIV(DIV), .DATA_W(12), .FRAME_CLKS(16)) i_adc_host_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .run_cont(run_cont), .strict(strict),
        .pwr_req(pwr_req), .wake_req(wake_req), .sdo(sdo), .conv(conv), .sclk(sclk),
        .sample(sample), .ready_flag(ready_flag), .sample_vld(sample_vld)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model (tick phases) ----------------
    int m_div, m_mode, m_ph, m_np;
    bit m_spend, m_wpend, m_vld, m_ready;
    logic [14:0] m_sh;
    logic [11:0] m_sample;

    function automatic bit m_conv();
        return (m_mode == 1 && m_ph == 0) || (m_mode == 2 && m_ph % 2 == 0);
    endfunction
    function automatic bit m_sclk();
        return (m_mode == 1 && m_ph > 0 && m_ph % 2 == 0) || m_mode == 4;
    endfunction

    always @(posedge clk) begin
        bit tk, go, launch, wnow;
        int old_mode;
        if (!rst_n) begin
            m_div = 0; m_mode = 0; m_ph = 0; m_np = 0; m_spend = 0; m_wpend = 0;
            m_vld = 0; m_ready = 0; m_sh = '0; m_sample = '0;
        end else begin
            tk = (m_div == DIV - 1);
            m_div = tk ? 0 : m_div + 1;
            go = m_spend || start || run_cont;
            wnow = m_wpend || wake_req;
            launch = 0;
            m_vld = 0;
            old_mode = m_mode;
            if (tk) begin
                case (m_mode)
                    0: if (go) begin m_mode = 1; m_ph = 0; launch = 1; end
                       else if (pwr_req != 2'b00) begin
                           m_mode = 2; m_ph = 0; m_np = pwr_req[1] ? 4 : 2;
                       end
                    1: if (m_ph % 2 == 1) begin
                           m_sh = {m_sh[13:0], sdo}; m_ph++;
                       end else if (m_ph == 32) begin
                           if (!(strict && !m_sh[14])) begin
                               m_sample = m_sh[13:2]; m_ready = m_sh[14]; m_vld = 1;
                           end
                           if (go) begin m_ph = 0; launch = 1; end
                           else m_mode = 0;
                       end else m_ph++;
                    2: if (m_ph == 2 * m_np - 1) m_mode = 3; else m_ph++;
                    3: if (wnow) m_mode = 4;
                    default: m_mode = 0;
                endcase
            end
            m_spend = (m_spend || start) && !launch;
            m_wpend = (old_mode == 3) && wnow && !tk;
        end
    end

    // ---------------- converter stand-in ----------------
    logic [15:0] wq[$];
    logic [15:0] cur_w = 16'hFFFF;
    int rises = 16;
    bit cv_prev = 0, sk_prev = 0;

    function automatic logic [15:0] mkw(input bit lead, input bit rdy, input logic [11:0] d, input logic [1:0] tail);
        return {lead, rdy, d, tail};
    endfunction

    // ---------------- monitor and per-cycle compare ----------------
    int cyc = 0, n_conv = 0, n_sclk = 0, n_vld = 0, last_conv = 0, conv_gap = 0, hi_len = 0, last_hi = 0;

    always @(negedge clk) begin
        cyc++;
        if (conv && !cv_prev) begin
            cur_w = (wq.size() > 0) ? wq.pop_front() : 16'hFFFF;
            rises = 0;
            n_conv++;
            conv_gap = cyc - last_conv;
            last_conv = cyc;
        end
        if (sclk && !sk_prev) begin
            rises++;
            n_sclk++;
        end
        if (sclk) hi_len++;
        else if (sk_prev) begin last_hi = hi_len; hi_len = 0; end
        if (sample_vld) n_vld++;
        cv_prev = conv;
        sk_prev = sclk;
        sdo <= (rises < 16) ? cur_w[15 - rises] : 1'b1;
        if (rst_n) begin
            chk(conv == m_conv(), "R2", "conv vs model", conv, m_conv());
            chk(sclk == m_sclk(), "R2", "sclk vs model", sclk, m_sclk());
            chk(sample == m_sample, "R4", "sample vs model", sample, m_sample);
            chk(ready_flag == m_ready, "R4", "ready vs model", ready_flag, m_ready);
            chk(sample_vld == m_vld, "R4", "strobe vs model", sample_vld, m_vld);
            chk(!(conv && sclk), "R11", "conv and sclk overlap", conv & sclk, 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_req = 1'b1;
        @(negedge clk) wake_req = 1'b0;
    endtask

    task automatic wait_vld(input int maxc, output bit found);
        found = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (sample_vld) begin found = 1; break; end
        end
    endtask

    task automatic req_power(input logic [1:0] code);
        @(negedge clk) pwr_req = code;
        while (!conv) @(negedge clk);
        pwr_req = 2'b00;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        bit f;
        int c0, s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(conv == 0 && sclk == 0 && sample_vld == 0, "R1", "pins after reset", {conv, sclk, sample_vld}, 0);
        chk(sample == 0 && ready_flag == 0, "R1", "sample after reset", sample, 0);

        // R3 basic frame, lead bit 0 and tail bits discarded
        wq.push_back(mkw(0, 1, 12'hABC, 2'b01));
        pulse_start();
        wait_vld(2 * FRM, f);
        chk(f, "R4", "strobe seen", f, 1);
        chk(sample == 12'hABC, "R3", "data bits", sample, 12'hABC);
        chk(ready_flag == 1, "R3", "ready bit", ready_flag, 1);
        chk(last_hi == DIV, "R2", "sclk high width", last_hi, DIV);

        // R4 ready 0 passes when not strict; lead 1 ignored
        wq.push_back(mkw(1, 0, 12'h001, 2'b10));
        pulse_start();
        wait_vld(2 * FRM, f);
        chk(sample == 12'h001 && ready_flag == 0, "R4", "lsb sample, ready 0", sample, 12'h001);

        // R5 strict drop
        strict = 1'b1;
        wq.push_back(mkw(1, 0, 12'h555, 2'b00));
        pulse_start();
        wait_vld(2 * FRM, f);
        chk(!f, "R5", "dropped frame strobe", f, 0);
        chk(sample == 12'h001, "R5", "sample kept", sample, 12'h001);
        wq.push_back(mkw(1, 1, 12'hFFF, 2'b00));
        pulse_start();
        wait_vld(2 * FRM, f);
        chk(f && sample == 12'hFFF, "R5", "strict accepts ready 1", sample, 12'hFFF);
        strict = 1'b0;
        repeat (4 * DIV) @(negedge clk);

        // R7 continuous
        wq.push_back(mkw(0, 1, 12'h123, 2'b11));
        wq.push_back(mkw(1, 1, 12'h456, 2'b00));
        wq.push_back(mkw(0, 1, 12'h789, 2'b10));
        wq.push_back(mkw(1, 1, 12'h800, 2'b01));
        @(negedge clk) run_cont = 1'b1;
        wait_vld(2 * FRM, f);
        chk(sample == 12'h123, "R7", "first stream sample", sample, 12'h123);
        wait_vld(2 * FRM, f);
        chk(sample == 12'h456, "R7", "second stream sample", sample, 12'h456);
        chk(conv_gap == FRM, "R7", "conv spacing", conv_gap, FRM);
        wait_vld(2 * FRM, f);
        chk(sample == 12'h789, "R7", "third stream sample", sample, 12'h789);
        run_cont = 1'b0;
        wait_vld(2 * FRM, f);
        chk(sample == 12'h800, "R7", "last stream sample", sample, 12'h800);
        repeat (4 * DIV) @(negedge clk);

        // R6 start during a frame chains
        wq.push_back(mkw(0, 1, 12'h0F0, 2'b00));
        wq.push_back(mkw(0, 1, 12'h70E, 2'b00));
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_vld(2 * FRM, f);
        chk(sample == 12'h0F0, "R6", "first chained", sample, 12'h0F0);
        wait_vld(2 * FRM, f);
        chk(f && sample == 12'h70E, "R6", "second chained", sample, 12'h70E);
        chk(conv_gap == FRM, "R6", "no idle tick", conv_gap, FRM);
        repeat (4 * DIV) @(negedge clk);

        // R8 light power-down, R9 parked behaviour
        c0 = n_conv; s0 = n_sclk;
        req_power(2'b01);
        repeat (20 * DIV) @(negedge clk);
        chk(n_conv - c0 == 2, "R8", "light pulses", n_conv - c0, 2);
        chk(n_sclk == s0, "R8", "sclk low in power-down", n_sclk - s0, 0);
        c0 = n_conv;
        pulse_start();
        repeat (20 * DIV) @(negedge clk);
        chk(n_conv == c0, "R9", "start held while parked", n_conv - c0, 0);
        wq.push_back(mkw(0, 1, 12'h3C5, 2'b00));
        s0 = n_sclk;
        pulse_wake();
        wait_vld(3 * FRM, f);
        chk(f && sample == 12'h3C5, "R9", "pending start after wake", sample, 12'h3C5);
        chk(n_sclk - s0 == 17, "R9", "wake pulse plus frame clocks", n_sclk - s0, 17);
        repeat (4 * DIV) @(negedge clk);

        // R8 deep power-down
        c0 = n_conv;
        req_power(2'b10);
        repeat (20 * DIV) @(negedge clk);
        chk(n_conv - c0 == 4, "R8", "deep pulses", n_conv - c0, 4);
        s0 = n_sclk;
        pulse_wake();
        repeat (10 * DIV) @(negedge clk);
        chk(n_sclk - s0 == 1, "R9", "single wake clock", n_sclk - s0, 1);

        // R9 wake outside PARK ignored
        s0 = n_sclk; c0 = n_conv;
        pulse_wake();
        repeat (10 * DIV) @(negedge clk);
        chk(n_sclk == s0 && n_conv == c0, "R9", "idle wake ignored", n_sclk - s0, 0);

        // R10 frame beats power request
        wq.push_back(mkw(1, 1, 12'h9A9, 2'b11));
        c0 = n_conv;
        @(negedge clk) begin start = 1'b1; pwr_req = 2'b01; end
        @(negedge clk) begin start = 1'b0; pwr_req = 2'b00; end
        wait_vld(2 * FRM, f);
        chk(f && sample == 12'h9A9, "R10", "frame taken", sample, 12'h9A9);
        repeat (10 * DIV) @(negedge clk);
        chk(n_conv - c0 == 1, "R10", "no power pulses", n_conv - c0, 1);

        finish_run();
    end
endmodule